// File: doc/BRIEF.md
# Packed-Entry Trap and Interrupt Controller

This block sits beside an instruction pipeline that can expand one 16-bit table-lookup instruction into a table entry holding one or two packed instructions. While such an entry is in flight, the architectural PC stays at the lookup instruction. The block decides when a pending interrupt may be accepted, records the exception PC for exceptions raised by either packed slot, and holds the two exception PC registers: one for the normal trap path and one for the non-maskable (double-trap) path.

Bit 0 of a recorded exception PC identifies the faulting slot: 0 for the first, 1 for the second. Unlike a conventional exception PC, bit 0 is kept in storage and returned unmasked. Software may clear it but never set it. For interrupts, the two instructions of an entry behave as one unit. An interrupt that arrives before the first slot commits abandons the entry. Once the first slot has committed, the interrupt waits until the whole entry is done. The pipeline signals entry start, per-slot commit and per-slot exception; the block answers one cycle later on registered outputs.

When no entry is in flight, a pending interrupt is accepted at once with the PC supplied by the pipeline. Cause encoding, privilege handling and vector computation are left to surrounding logic.

Top module: `lte_trap_ctrl`

## Requirements
- R1: After synchronous reset, irq_take, trap_take, ret_valid, trap_pc, ret_pc, epc and nepc are all zero, and no entry is in flight.
- R2: With no entry in flight, a pending interrupt is taken: irq_take pulses one cycle later with trap_pc and epc equal to core_pc with bit 0 cleared. An entry start in that same cycle is discarded.
- R3: An interrupt pending while an entry's first slot has neither committed nor faulted is taken at once. It records the entry's PC with bit 0 cleared, and the abandoned entry accepts no further commit or exception strobes.
- R4: In a two-slot entry, a first-slot commit (including one in the same cycle as the interrupt) holds the interrupt off. The interrupt is taken in the cycle the second slot commits, and it records the entry PC plus 2.
- R5: In a one-slot entry, the slot's commit ends the entry. An interrupt pending in that cycle is taken with entry PC plus 2, and later interrupts are taken as in R2.
- R6: An exception on the first slot pulses trap_take and records the entry PC with bit 0 = 0.
- R7: An exception on the second slot, after the first has committed, pulses trap_take and records the entry PC with bit 0 = 1.
- R8: An exception has priority over an interrupt pending in the same cycle. The interrupt is not taken that cycle, and irq_take and trap_take are never high together.
- R9: When dbl_trap is high with an exception, the recorded value goes to nepc and epc keeps its value. Interrupts always record into epc.
- R10: A software write sets bits XLEN-1:1 of the target register from csr_wdata. Bit 0 becomes csr_wdata[0] AND the old bit 0, so a write can clear bit 0 but not set it. A trap record in the same cycle overrides the write.
- R11: xret pulses ret_valid one cycle later. ret_pc then equals the full value of epc (xret_nmi=0) or nepc (xret_nmi=1), bit 0 included. Neither register changes because of the return.
- R12: While an entry is in flight, a new entry start is ignored. While none is in flight, commit and exception strobes produce no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | 1 | A lookup instruction starts an entry this cycle |
| ent_pc | input | XLEN | Address of the lookup instruction |
| ent_dual | input | 1 | Entry holds two instructions (1) or one (0) |
| core_pc | input | XLEN | Resume PC used for interrupts when no entry is in flight |
| irq_pending | input | 1 | An enabled interrupt is pending |
| slot_commit | input | 2 | Bit 0: first slot commits; bit 1: second slot commits |
| slot_exc | input | 2 | Bit 0: first slot faults; bit 1: second slot faults |
| dbl_trap | input | 1 | The exception this cycle goes to the non-maskable path |
| epc_wr | input | 1 | Software write to epc |
| nepc_wr | input | 1 | Software write to nepc |
| csr_wdata | input | XLEN | Software write data |
| xret | input | 1 | Return-from-trap strobe |
| xret_nmi | input | 1 | Return uses nepc (1) or epc (0) |
| irq_take | output | 1 | Interrupt accepted (registered pulse) |
| trap_take | output | 1 | Exception taken (registered pulse) |
| trap_pc | output | XLEN | PC recorded by the last accepted trap or interrupt |
| epc | output | XLEN | Normal exception PC register |
| nepc | output | XLEN | Non-maskable exception PC register |
| ret_valid | output | 1 | Return target valid (registered pulse) |
| ret_pc | output | XLEN | Return target, bit 0 kept |

## Verification
The bench builds the block with XLEN = 32 and a lookup instruction length of 2 bytes. At these values the bench can use entry addresses whose upper bits are set and check bit 0 end to end. Directed sequences cover every point at which an interrupt can meet a one- or two-slot entry and both slot exceptions on each trap path, along with the bit-0 write rule. A long random phase then mixes every input against a cycle-accurate behavioural model, which reaches coincidences such as an exception, a software write and a return in one cycle.

// File: rtl/lte_pkg.sv
package lte_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;

  localparam int NUM_EPC = 2;
  localparam int EPC_STD = 0;
  localparam int EPC_NMI = 1;
endpackage

// File: rtl/lte_seq.sv
module lte_seq
  import lte_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ent_valid,
  input  logic [XLEN-1:0] ent_pc,
  input  logic            ent_dual,
  input  logic [XLEN-1:0] core_pc,
  input  logic            irq_pending,
  input  logic [1:0]      slot_commit,
  input  logic [1:0]      slot_exc,
  output logic            irq_go,
  output logic            exc_go,
  output logic [XLEN-1:0] rec_pc
);
  localparam logic [XLEN-1:0] BIT0 = XLEN'(1);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  phase_t          ph_q, ph_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            dual_q, dual_d;
  logic [XLEN-1:0] after_pc;

  assign after_pc = pc_q + STEP;

  always_comb begin
    ph_d   = ph_q;
    pc_d   = pc_q;
    dual_d = dual_q;
    irq_go = 1'b0;
    exc_go = 1'b0;
    rec_pc = pc_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (irq_pending) begin
          irq_go = 1'b1;
          rec_pc = core_pc & ~BIT0;
        end else if (ent_valid) begin
          ph_d   = PH_FIRST;
          pc_d   = ent_pc & ~BIT0;
          dual_d = ent_dual;
        end
      end
      PH_FIRST: begin
        if (slot_exc[0]) begin
          exc_go = 1'b1;
          rec_pc = pc_q;
          ph_d   = PH_IDLE;
        end else if (slot_commit[0]) begin
          if (dual_q) begin
            ph_d = PH_SECOND;
          end else begin
            ph_d = PH_IDLE;
            if (irq_pending) begin
              irq_go = 1'b1;
              rec_pc = after_pc;
            end
          end
        end else if (irq_pending) begin
          irq_go = 1'b1;
          rec_pc = pc_q;
          ph_d   = PH_IDLE;
        end
      end
      PH_SECOND: begin
        if (slot_exc[1]) begin
          exc_go = 1'b1;
          rec_pc = pc_q | BIT0;
          ph_d   = PH_IDLE;
        end else if (slot_commit[1]) begin
          ph_d = PH_IDLE;
          if (irq_pending) begin
            irq_go = 1'b1;
            rec_pc = after_pc;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      pc_q   <= '0;
      dual_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pc_q   <= pc_d;
      dual_q <= dual_d;
    end
  end

  // R4
  hold_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SECOND && !slot_commit[1]) |-> !irq_go);

  // R8
  exc_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FIRST && slot_exc[0]) |-> (exc_go && !irq_go));

  // R12
  idle_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE) |-> !exc_go);
endmodule

// File: rtl/lte_epc_reg.sv
module lte_epc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_we,
  input  logic [XLEN-1:0] trap_val,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_val,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (trap_we) begin
      q <= trap_val;
    end else if (sw_we) begin
      q <= {sw_val[XLEN-1:1], sw_val[0] & q[0]};
    end
  end

  // R10
  bit0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_we && !q[0]) |=> !q[0]);
endmodule

// File: rtl/lte_ret.sv
module lte_ret #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xret,
  input  logic            xret_nmi,
  input  logic [XLEN-1:0] epc_q,
  input  logic [XLEN-1:0] nepc_q,
  output logic            ret_valid,
  output logic [XLEN-1:0] ret_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_pc    <= '0;
    end else begin
      ret_valid <= xret;
      if (xret) ret_pc <= xret_nmi ? nepc_q : epc_q;
    end
  end
endmodule

// File: rtl/lte_trap_ctrl.sv
module lte_trap_ctrl
  import lte_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ent_valid,
  input  logic [XLEN-1:0] ent_pc,
  input  logic            ent_dual,
  input  logic [XLEN-1:0] core_pc,
  input  logic            irq_pending,
  input  logic [1:0]      slot_commit,
  input  logic [1:0]      slot_exc,
  input  logic            dbl_trap,
  input  logic            epc_wr,
  input  logic            nepc_wr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            xret,
  input  logic            xret_nmi,
  output logic            irq_take,
  output logic            trap_take,
  output logic [XLEN-1:0] trap_pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] nepc,
  output logic            ret_valid,
  output logic [XLEN-1:0] ret_pc
);
  logic            irq_go, exc_go;
  logic [XLEN-1:0] rec_pc;
  logic [NUM_EPC-1:0] trap_we, sw_we;
  logic [XLEN-1:0] reg_q [NUM_EPC];

  lte_seq #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ent_valid  (ent_valid),
    .ent_pc     (ent_pc),
    .ent_dual   (ent_dual),
    .core_pc    (core_pc),
    .irq_pending(irq_pending),
    .slot_commit(slot_commit),
    .slot_exc   (slot_exc),
    .irq_go     (irq_go),
    .exc_go     (exc_go),
    .rec_pc     (rec_pc)
  );

  assign trap_we[EPC_STD] = irq_go | (exc_go & ~dbl_trap);
  assign trap_we[EPC_NMI] = exc_go & dbl_trap;
  assign sw_we[EPC_STD]   = epc_wr;
  assign sw_we[EPC_NMI]   = nepc_wr;

  for (genvar g = 0; g < NUM_EPC; g++) begin : g_epc
    lte_epc_reg #(.XLEN(XLEN)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .trap_we (trap_we[g]),
      .trap_val(rec_pc),
      .sw_we   (sw_we[g]),
      .sw_val  (csr_wdata),
      .q       (reg_q[g])
    );
  end

  assign epc  = reg_q[EPC_STD];
  assign nepc = reg_q[EPC_NMI];

  lte_ret #(.XLEN(XLEN)) u_ret (
    .clk      (clk),
    .rst      (rst),
    .xret     (xret),
    .xret_nmi (xret_nmi),
    .epc_q    (epc),
    .nepc_q   (nepc),
    .ret_valid(ret_valid),
    .ret_pc   (ret_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take  <= 1'b0;
      trap_take <= 1'b0;
      trap_pc   <= '0;
    end else begin
      irq_take  <= irq_go;
      trap_take <= exc_go;
      if (irq_go || exc_go) trap_pc <= rec_pc;
    end
  end

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_take, trap_take}));

  // R3
  irq_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !trap_pc[0]);

  // R11
  ret_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (xret && !epc_wr && !nepc_wr && !irq_go && !exc_go) |=> ($stable(epc) && $stable(nepc)));

  // R9
  nmi_route_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_go && dbl_trap && !epc_wr) |=> $stable(epc));
endmodule

// File: tb/lte_trap_ctrl_tb.sv
module lte_trap_ctrl_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ent_valid = 0, ent_dual = 0, irq_pending = 0, dbl_trap = 0;
  logic epc_wr = 0, nepc_wr = 0, xret = 0, xret_nmi = 0;
  logic [1:0] slot_commit = 0, slot_exc = 0;
  logic [XLEN-1:0] ent_pc = 0, core_pc = 0, csr_wdata = 0;
  logic irq_take, trap_take, ret_valid;
  logic [XLEN-1:0] trap_pc, epc, nepc, ret_pc;

  always #10 clk = ~clk;

  lte_trap_ctrl #(.XLEN(XLEN), .INSN_BYTES(2)) u_dut (
    .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_dual(ent_dual),
    .core_pc(core_pc), .irq_pending(irq_pending), .slot_commit(slot_commit),
    .slot_exc(slot_exc), .dbl_trap(dbl_trap), .epc_wr(epc_wr), .nepc_wr(nepc_wr),
    .csr_wdata(csr_wdata), .xret(xret), .xret_nmi(xret_nmi), .irq_take(irq_take),
    .trap_take(trap_take), .trap_pc(trap_pc), .epc(epc), .nepc(nepc),
    .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // behavioural reference: 0 no entry, 1 waiting on slot one, 2 waiting on slot two
  int m_state = 0;
  logic [31:0] m_pc = 0;
  bit m_dual = 0;
  bit e_irq = 0, e_trap = 0, e_rv = 0;
  logic [31:0] e_tpc = 0, e_epc = 0, e_nepc = 0, e_rpc = 0;

  always @(posedge clk) begin
    bit take_i, take_e;
    logic [31:0] rec, old_epc, old_nepc;
    if (rst) begin
      m_state = 0; m_pc = 0; m_dual = 0;
      e_irq = 0; e_trap = 0; e_rv = 0;
      e_tpc = 0; e_epc = 0; e_nepc = 0; e_rpc = 0;
    end else begin
      take_i = 0; take_e = 0; rec = 0;
      old_epc = e_epc; old_nepc = e_nepc;
      if (m_state == 0) begin
        if (irq_pending) begin take_i = 1; rec = {core_pc[31:1], 1'b0}; end
        else if (ent_valid) begin m_state = 1; m_pc = {ent_pc[31:1], 1'b0}; m_dual = ent_dual; end
      end else if (m_state == 1) begin
        if (slot_exc[0]) begin take_e = 1; rec = m_pc; m_state = 0; end
        else if (slot_commit[0]) begin
          if (m_dual) m_state = 2;
          else begin
            m_state = 0;
            if (irq_pending) begin take_i = 1; rec = m_pc + 2; end
          end
        end else if (irq_pending) begin take_i = 1; rec = m_pc; m_state = 0; end
      end else begin
        if (slot_exc[1]) begin take_e = 1; rec = m_pc + 1; m_state = 0; end
        else if (slot_commit[1]) begin
          m_state = 0;
          if (irq_pending) begin take_i = 1; rec = m_pc + 2; end
        end
      end
      if (epc_wr)  e_epc  = {csr_wdata[31:1], csr_wdata[0] & old_epc[0]};
      if (nepc_wr) e_nepc = {csr_wdata[31:1], csr_wdata[0] & old_nepc[0]};
      if (take_i || (take_e && !dbl_trap)) e_epc = rec;
      if (take_e && dbl_trap) e_nepc = rec;
      e_irq = take_i; e_trap = take_e;
      if (take_i || take_e) e_tpc = rec;
      e_rv = xret;
      if (xret) e_rpc = xret_nmi ? old_nepc : old_epc;
    end
  end

  task automatic check(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%s expected=%s", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check({irq_take, trap_take, ret_valid} == {e_irq, e_trap, e_rv}, "strobes",
            $sformatf("%b%b%b", irq_take, trap_take, ret_valid),
            $sformatf("%b%b%b", e_irq, e_trap, e_rv));
      check(trap_pc == e_tpc, "trap_pc", $sformatf("%h", trap_pc), $sformatf("%h", e_tpc));
      check(epc == e_epc && nepc == e_nepc, "epc/nepc",
            $sformatf("%h/%h", epc, nepc), $sformatf("%h/%h", e_epc, e_nepc));
      check(ret_pc == e_rpc, "ret_pc", $sformatf("%h", ret_pc), $sformatf("%h", e_rpc));
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    ent_valid = 0; ent_dual = 0; irq_pending = 0; dbl_trap = 0;
    epc_wr = 0; nepc_wr = 0; xret = 0; xret_nmi = 0;
    slot_commit = 0; slot_exc = 0;
  endtask

  task automatic start_entry(input logic [31:0] pc, input bit dual);
    quiet(); ent_valid = 1; ent_pc = pc; ent_dual = dual; cyc(); quiet();
  endtask

  initial begin
    rst = 1; cyc(3); rst = 0;
    // R1 reset state
    cur_req = "R1";
    check({irq_take, trap_take, ret_valid} == 3'b000 && trap_pc == 0 && epc == 0 && nepc == 0 && ret_pc == 0,
          "reset", $sformatf("%h %h", epc, trap_pc), "0 0");
    cyc(2);

    // R2 idle interrupt, simultaneous entry start dropped
    cur_req = "R2";
    core_pc = 32'h0000_0101; irq_pending = 1; ent_valid = 1; ent_pc = 32'h9000; cyc(); quiet(); cyc();
    check(epc == 32'h100, "R2 epc", $sformatf("%h", epc), "00000100");
    slot_exc = 2'b11; slot_commit = 2'b11; cyc(); quiet(); cyc();

    // R12 idle strobes produce no trap (model compares trap_take each cycle)
    cur_req = "R12";
    slot_exc = 2'b01; cyc(); quiet(); cyc();

    // R3 interrupt before first commit abandons entry
    cur_req = "R3";
    start_entry(32'h8000_2000, 1);
    irq_pending = 1; cyc(); quiet(); cyc();
    check(epc == 32'h8000_2000, "R3 epc", $sformatf("%h", epc), "80002000");
    slot_commit = 2'b01; slot_exc = 2'b10; cyc(); quiet(); cyc();

    // R4 hold interrupt across two-slot entry; R12 new start ignored
    cur_req = "R4";
    start_entry(32'h0000_3000, 1);
    slot_commit = 2'b01; irq_pending = 1; cyc();
    slot_commit = 0; ent_valid = 1; ent_pc = 32'h7777_0000; cyc(); ent_valid = 0; cyc(2);
    slot_commit = 2'b10; cyc(); quiet(); cyc();
    check(epc == 32'h3002, "R4 epc", $sformatf("%h", epc), "00003002");

    // R5 one-slot entry: commit with interrupt, then normal acceptance
    cur_req = "R5";
    start_entry(32'h0000_4010, 0);
    slot_commit = 2'b01; irq_pending = 1; cyc(); quiet(); cyc();
    check(epc == 32'h4012, "R5 epc", $sformatf("%h", epc), "00004012");
    start_entry(32'h0000_4100, 0);
    slot_commit = 2'b01; cyc(); quiet(); core_pc = 32'h4104; irq_pending = 1; cyc(); quiet(); cyc();

    // R6 and R8 first-slot exception beats interrupt
    cur_req = "R8";
    start_entry(32'h0000_5000, 1);
    slot_exc = 2'b01; irq_pending = 1; cyc(); slot_exc = 0; cyc(); quiet(); cyc();
    cur_req = "R6";
    start_entry(32'h0000_5100, 0);
    slot_exc = 2'b01; cyc(); quiet(); cyc();
    check(epc == 32'h5100, "R6 epc", $sformatf("%h", epc), "00005100");

    // R7 second-slot exception sets bit 0
    cur_req = "R7";
    start_entry(32'h0000_6000, 1);
    slot_commit = 2'b01; cyc(); quiet(); slot_exc = 2'b10; cyc(); quiet(); cyc();
    check(epc == 32'h6001, "R7 epc", $sformatf("%h", epc), "00006001");

    // R9 double trap records into nepc only
    cur_req = "R9";
    start_entry(32'h0000_7000, 1);
    slot_commit = 2'b01; cyc(); quiet(); slot_exc = 2'b10; dbl_trap = 1; cyc(); quiet(); cyc();
    check(nepc == 32'h7001 && epc == 32'h6001, "R9 regs", $sformatf("%h/%h", epc, nepc), "00006001/00007001");

    // R11 return keeps bit 0
    cur_req = "R11";
    xret = 1; cyc(); quiet(); cyc();
    check(ret_pc == 32'h6001, "R11 ret", $sformatf("%h", ret_pc), "00006001");
    xret = 1; xret_nmi = 1; cyc(); quiet(); cyc();
    check(ret_pc == 32'h7001 && nepc == 32'h7001, "R11 nmi ret", $sformatf("%h", ret_pc), "00007001");

    // R10 software write rules
    cur_req = "R10";
    epc_wr = 1; csr_wdata = 32'h1234_0001; cyc(); quiet(); cyc();
    check(epc == 32'h1234_0001, "R10 keep", $sformatf("%h", epc), "12340001");
    epc_wr = 1; csr_wdata = 32'h1234_0000; cyc(); quiet(); cyc();
    epc_wr = 1; nepc_wr = 1; csr_wdata = 32'hABCD_0003; cyc(); quiet(); cyc();
    check(epc == 32'hABCD_0002, "R10 no set", $sformatf("%h", epc), "abcd0002");
    start_entry(32'h0000_0A00, 0);
    slot_exc = 2'b01; epc_wr = 1; csr_wdata = 32'h5555_5555; cyc(); quiet(); cyc();
    check(epc == 32'h0A00, "R10 trap wins", $sformatf("%h", epc), "00000a00");

    // mixed random traffic against the model (R4 R7 R10 R12 coincidences)
    cur_req = "R12";
    for (int k = 0; k < 4000; k++) begin
      ent_valid   = ($urandom % 3) == 0;
      ent_pc      = $urandom;
      ent_dual    = $urandom % 2;
      core_pc     = $urandom;
      irq_pending = ($urandom % 5) == 0;
      slot_commit = 2'($urandom % 4);
      slot_exc    = 2'(($urandom % 6 == 0) ? ($urandom % 4) : 0);
      dbl_trap    = $urandom % 2;
      epc_wr      = ($urandom % 8) == 0;
      nepc_wr     = ($urandom % 8) == 0;
      csr_wdata   = $urandom;
      xret        = ($urandom % 6) == 0;
      xret_nmi    = $urandom % 2;
      cyc();
    end
    quiet(); cyc(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule